// File: doc/BRIEF.md
# Multiplexed GPIO Port Bank

This block is a bank of general-purpose I/O ports reached over a small register bus. Every port has three registers: an output latch, a per-bit direction register and, on the ports that support it, a per-bit pull-up register. Software drives a pin by loading its latch and marking the bit as an output. It reads a pin back through the same latch address. Bits set as outputs return the latch value. Bits set as inputs return the pad input.

One port shares its pins with analog converter inputs. On that port an analog-enable register decides, bit by bit, whether the digital input path is usable. It comes out of reset with every implemented bit set, so all of those pins start as analog. A standby input cuts every input buffer in the bank at once. A blocked input reads as 0. Ports have different widths, and bits that are not implemented are absent: they read 0, ignore writes and hold their pad outputs low.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all data, direction and pull-up registers read 0, pad_oe and pad_pu are all 0, and the analog-enable register of the analog port (port 5) reads 0xFF.
- R2: A write to a data register (register select 0) updates pad_out for that port on the next cycle whatever the direction bits hold, so an output value can be loaded before the bit is turned into an output.
- R3: The direction register (register select 1) sets pad_oe bit by bit (1 = output), independently for every bit.
- R4: A data-register read returns the latch value in bits whose direction is 1 and the pad input in bits whose direction is 0.
- R5: Only ports 0 and 1 have a pull-up register (register select 2). pad_pu for a bit is the pull-up bit AND NOT the direction bit, so it is never on for an output.
- R6: On port 5 an analog-enable bit (register select 3) of 1 blocks the digital input: a data read of that bit, if it is an input, returns 0.
- R7: While standby is 1, every input bit on every port reads 0, and output bits still return their latch value.
- R8: Port widths are 8,8,8,8,7,8,4 for ports 0 to 6. Unimplemented bits read 0, ignore writes and keep pad_out, pad_oe and pad_pu at 0.
- R9: bus_addr[4:2] selects the port and bus_addr[1:0] the register. A pull-up access on ports 2 to 6, an analog-enable access on any port other than 5, and any access to port 7 read 0 and change nothing. A read in the cycle of a write to the same register returns the old value.
- R10: Registers change only when bus_sel and bus_wr are both 1 at a clock edge. With bus_sel at 0, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Port index in [4:2], register select in [1:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| standby | input | 1 | Cuts every input buffer while 1 |
| pad_in | input | 56 | Pad input levels, port p in bits [8p+7:8p] |
| pad_out | output | 56 | Pad output levels |
| pad_oe | output | 56 | Pad output enables |
| pad_pu | output | 56 | Pad pull-up enables |

## Verification
Two functions can meet in one cycle. A bus write can land while the same register is being read, and the analog or standby gating can act while a data read mixes output and input bits. The bench places a direction write and a look at bus_rdata in the same cycle and expects the old value, then the new value one cycle later. With standby and analog-enable bits set over mixed direction patterns, it expects output bits from the latch and each blocked input bit as 0. Expected words come from per-port masks built from the port widths.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_BITS = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_AEN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter logic [PORT_BITS-1:0] MASK = '1,
  parameter bit HAS_PULL = 1'b0,
  parameter bit HAS_AEN  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_data,
  input  logic                 wr_dir,
  input  logic                 wr_pull,
  input  logic                 wr_aen,
  input  logic [PORT_BITS-1:0] wdata,
  input  logic [PORT_BITS-1:0] pin_in,
  input  logic                 standby,
  output logic [PORT_BITS-1:0] rd_data,
  output logic [PORT_BITS-1:0] rd_dir,
  output logic [PORT_BITS-1:0] rd_pull,
  output logic [PORT_BITS-1:0] rd_aen,
  output logic [PORT_BITS-1:0] pad_out,
  output logic [PORT_BITS-1:0] pad_oe,
  output logic [PORT_BITS-1:0] pad_pu
);
  logic [PORT_BITS-1:0] data_q, data_nxt;
  logic [PORT_BITS-1:0] dir_q, dir_nxt;
  logic [PORT_BITS-1:0] pull_val;
  logic [PORT_BITS-1:0] aen_val;
  logic [PORT_BITS-1:0] blocked;
  logic [PORT_BITS-1:0] pin_seen;

  // next state with explicit clock enables
  always_comb begin
    data_nxt = wr_data ? (wdata & MASK) : data_q;
    dir_nxt  = wr_dir  ? (wdata & MASK) : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
    end
  end

  if (HAS_PULL) begin : g_pull
    logic [PORT_BITS-1:0] pull_q, pull_nxt;
    always_comb pull_nxt = wr_pull ? (wdata & MASK) : pull_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pull_q <= '0;
      else        pull_q <= pull_nxt;
    end
    assign pull_val = pull_q;
  end else begin : g_nopull
    logic unused_pull_wr;
    assign unused_pull_wr = wr_pull;
    assign pull_val = '0;
  end

  if (HAS_AEN) begin : g_aen
    logic [PORT_BITS-1:0] aen_q, aen_nxt;
    always_comb aen_nxt = wr_aen ? (wdata & MASK) : aen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aen_q <= MASK;
      else        aen_q <= aen_nxt;
    end
    assign aen_val = aen_q;
  end else begin : g_noaen
    logic unused_aen_wr;
    assign unused_aen_wr = wr_aen;
    assign aen_val = '0;
  end

  // input buffer gating: analog selection or standby cut the pin off
  always_comb begin
    blocked  = aen_val | {PORT_BITS{standby}};
    pin_seen = pin_in & ~blocked & MASK;
    rd_data  = (dir_q & data_q) | (~dir_q & pin_seen);
  end

  assign rd_dir  = dir_q;
  assign rd_pull = pull_val;
  assign rd_aen  = aen_val;
  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign pad_pu  = pull_val & ~dir_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter logic [NUM_PORTS*PORT_BITS-1:0] PORT_MASKS =
    {8'h0F, 8'hFF, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
  parameter logic [NUM_PORTS-1:0] PULL_PORTS = 7'b0000011,
  parameter int ANALOG_PORT = 5,
  localparam int NPIN   = NUM_PORTS * PORT_BITS,
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W = PIDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PORT_BITS-1:0] bus_wdata,
  output logic [PORT_BITS-1:0] bus_rdata,
  input  logic                 standby,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_pu
);
  logic                rst_core_n;
  logic [PIDX_W-1:0]   port_idx;
  reg_sel_e            reg_sel;
  logic                wr_hit;

  logic [PORT_BITS-1:0] rd_data_a [NUM_PORTS];
  logic [PORT_BITS-1:0] rd_dir_a  [NUM_PORTS];
  logic [PORT_BITS-1:0] rd_pull_a [NUM_PORTS];
  logic [PORT_BITS-1:0] rd_aen_a  [NUM_PORTS];

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign port_idx = bus_addr[ADDR_W-1:2];
  assign reg_sel  = reg_sel_e'(bus_addr[1:0]);
  assign wr_hit   = bus_sel & bus_wr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_hit && (int'(port_idx) == p);

    gpio_port #(
      .MASK     (PORT_MASKS[p*PORT_BITS +: PORT_BITS]),
      .HAS_PULL (PULL_PORTS[p]),
      .HAS_AEN  (p == ANALOG_PORT)
    ) u_port (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_data (hit && (reg_sel == SEL_DATA)),
      .wr_dir  (hit && (reg_sel == SEL_DIR)),
      .wr_pull (hit && (reg_sel == SEL_PULL)),
      .wr_aen  (hit && (reg_sel == SEL_AEN)),
      .wdata   (bus_wdata),
      .pin_in  (pad_in[p*PORT_BITS +: PORT_BITS]),
      .standby (standby),
      .rd_data (rd_data_a[p]),
      .rd_dir  (rd_dir_a[p]),
      .rd_pull (rd_pull_a[p]),
      .rd_aen  (rd_aen_a[p]),
      .pad_out (pad_out[p*PORT_BITS +: PORT_BITS]),
      .pad_oe  (pad_oe[p*PORT_BITS +: PORT_BITS]),
      .pad_pu  (pad_pu[p*PORT_BITS +: PORT_BITS])
    );
  end

  // read return, selected by port index and register select
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_sel && (int'(port_idx) == p)) begin
        case (reg_sel)
          SEL_DATA: bus_rdata = rd_data_a[p];
          SEL_DIR:  bus_rdata = rd_dir_a[p];
          SEL_PULL: bus_rdata = rd_pull_a[p];
          default:  bus_rdata = rd_aen_a[p];
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter logic [NUM_PORTS*PORT_BITS-1:0] PORT_MASKS = '1,
  localparam int NPIN   = NUM_PORTS * PORT_BITS,
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W = PIDX_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [PORT_BITS-1:0] bus_wdata,
  input logic [PORT_BITS-1:0] bus_rdata,
  input logic                 standby,
  input logic [NPIN-1:0]      pad_in,
  input logic [NPIN-1:0]      pad_out,
  input logic [NPIN-1:0]      pad_oe,
  input logic [NPIN-1:0]      pad_pu
);
  logic [PORT_BITS-1:0] sel_oe;
  logic                 unused_chk;

  assign unused_chk = ^{bus_wdata, pad_in};

  always_comb begin
    sel_oe = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (int'(bus_addr[ADDR_W-1:2]) == p) sel_oe = pad_oe[p*PORT_BITS +: PORT_BITS];
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0) && (pad_pu == '0));

  // R5
  pull_not_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R8
  absent_bits_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe | pad_pu) & ~PORT_MASKS) == '0);

  // R10
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_out) && $stable(pad_oe) && $stable(pad_pu));

  // R7
  standby_inputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && bus_sel && !bus_wr && (bus_addr[1:0] == 2'd0)) |->
      ((bus_rdata & ~sel_oe) == '0));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .PORT_MASKS (PORT_MASKS)
) u_chk (.*);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        standby;
  logic [55:0] pad_in, pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  int widths [7] = '{8, 8, 8, 8, 7, 8, 4};

  always #2 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .standby(standby), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  function automatic logic [7:0] mask_of(input int p);
    return 8'((16'd1 << widths[p]) - 16'd1);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input int p, input int r, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1;
    bus_addr = {p[2:0], r[1:0]}; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int p, input int r, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {p[2:0], r[1:0]};
    #1 v = bus_rdata;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] v, exp, dpat, ppat, aen;
    logic [7:0] dirs [5] = '{8'h00, 8'hFF, 8'h0F, 8'h3C, 8'h81};
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; standby = 1'b0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int p = 0; p < 7; p++) begin
      rd(p, 0, v); check("R1 data", v, 8'h00);
      rd(p, 1, v); check("R1 dir", v, 8'h00);
      rd(p, 2, v); check("R1 pull", v, 8'h00);
      check("R1 oe", pad_oe[p*8 +: 8], 8'h00);
      check("R1 pu", pad_pu[p*8 +: 8], 8'h00);
    end
    rd(5, 3, v); check("R1 aen", v, 8'hFF);

    // R2, R3: preload latch then sweep directions
    for (int p = 0; p < 7; p++) begin
      dpat = 8'hA5 ^ 8'(p * 17);
      wr(p, 0, dpat);
      check("R2 preload out", pad_out[p*8 +: 8], dpat & mask_of(p));
      check("R2 oe still off", pad_oe[p*8 +: 8], 8'h00);
      for (int k = 0; k < 5; k++) begin
        wr(p, 1, dirs[k]);
        check("R3 oe", pad_oe[p*8 +: 8], dirs[k] & mask_of(p));
        check("R3 out kept", pad_out[p*8 +: 8], dpat & mask_of(p));
      end
    end

    // R4: open analog port, then sweep direction x pin patterns
    wr(5, 3, 8'h00);
    for (int p = 0; p < 7; p++) begin
      dpat = 8'h5A + 8'(p);
      wr(p, 0, dpat);
      for (int k = 0; k < 5; k++) begin
        wr(p, 1, dirs[k]);
        for (int j = 0; j < 8; j++) begin
          ppat = 8'(j * 37 + p * 11);
          pad_in[p*8 +: 8] = ppat;
          rd(p, 0, v);
          exp = ((dirs[k] & dpat) | (~dirs[k] & ppat)) & mask_of(p);
          check("R4 data read", v, exp);
        end
      end
    end

    // R5 pull-up only on ports 0,1 and only for inputs
    for (int p = 0; p < 7; p++) begin
      wr(p, 1, 8'h0F);
      wr(p, 2, 8'hFF);
      exp = (p < 2) ? 8'hF0 : 8'h00;
      check("R5 pu pad", pad_pu[p*8 +: 8], exp & mask_of(p));
      rd(p, 2, v);
      check("R5 pull read", v, (p < 2) ? mask_of(p) : 8'h00);
    end

    // R6 analog enable on port 5
    pad_in[40 +: 8] = 8'hFF;
    wr(5, 0, 8'hAA);
    for (int k = 0; k < 4; k++) begin
      aen = 8'(8'hF0 >> k) ^ 8'(k * 51);
      wr(5, 3, aen);
      wr(5, 1, 8'h00);
      rd(5, 0, v); check("R6 all inputs", v, ~aen);
      wr(5, 1, 8'hF0);
      rd(5, 0, v); check("R6 mixed", v, (8'hF0 & 8'hAA) | (8'h0F & ~aen));
    end
    wr(5, 3, 8'h00);

    // R7 standby blocks all inputs, outputs still from latch
    pad_in = '1;
    standby = 1'b1;
    for (int p = 0; p < 7; p++) begin
      wr(p, 0, 8'hC3);
      wr(p, 1, 8'h0F);
      rd(p, 0, v); check("R7 standby read", v, 8'h03 & mask_of(p));
    end
    standby = 1'b0;
    rd(3, 0, v); check("R7 standby off", v, 8'hF3);

    // R8 absent bits
    wr(6, 0, 8'hFF); wr(6, 1, 8'hFF);
    check("R8 port6 out", pad_out[48 +: 8], 8'h0F);
    rd(6, 1, v); check("R8 port6 dir", v, 8'h0F);
    wr(4, 1, 8'h80); rd(4, 1, v); check("R8 port4 bit7", v, 8'h00);
    check("R8 port4 oe", pad_oe[32 +: 8], 8'h00);

    // R9 map holes and write/read in one cycle
    wr(3, 2, 8'hFF); rd(3, 2, v); check("R9 pull hole", v, 8'h00);
    check("R9 pu pad", pad_pu[24 +: 8], 8'h00);
    wr(2, 3, 8'hFF); rd(2, 3, v); check("R9 aen hole", v, 8'h00);
    wr(7, 0, 8'hFF); rd(7, 0, v); check("R9 port7", v, 8'h00);
    wr(2, 1, 8'h11);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {3'd2, 2'd1}; bus_wdata = 8'h66;
    #1 check("R9 old in write cycle", bus_rdata, 8'h11);
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R9 new after write", bus_rdata, 8'h66);

    // R10 no write without both strobes
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {3'd2, 2'd1}; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1;
    #1 check("R10 idle rdata", bus_rdata, 8'h00);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2, 1, v); check("R10 dir kept", v, 8'h66);
    check("R10 oe kept", pad_oe[16 +: 8], 8'h66);

    report();
  end
endmodule